// File: doc/BRIEF.md
# Extended-Data-Out DRAM Output Control

This block is a clocked behavioural model of the data-output side of an extended-data-out DRAM. On every clock it samples the active-low row strobe, column strobe, write enable and output enable. From those levels and from edges found by comparing each sample with the one before, it decides three things: whether the data pins drive the latched read word, which word that is, and whether a write is committed to its small internal test array.

Its key difference from a fast-page part is that read data is not dropped when the column strobe rises. The word stays on the pins until the output enable is toggled, a write enable pulse arrives while the column strobe is high, or a programmable turn-off delay runs out after both strobes have returned high. Write handling tells an early write apart from a late (read-modify-write) write. A late write issued while the output enable is still asserted is refused.

It is meant for controller verification and for system models that need cycle-accurate DQ ownership without analog timing.

Top module: `edo_dq_ctrl`

## Requirements
- R1: During and after reset, with all strobes high, `dq_oe` and `wr_commit` are 0.
- R2: When the column strobe falls while the row strobe is low and write enable is high, the word stored at index `row*2^COL_W + col` is latched as read data. With output enable low, `dq_oe` is 1 and `dq_out` carries that word after the same sampling edge.
- R3: While a read word is held, a rise of the column strobe with the row and output enables still low leaves `dq_oe` at 1 and `dq_out` unchanged.
- R4: With both strobes low, raising output enable turns `dq_oe` off. Lowering it again restores `dq_oe` with the same `dq_out` word.
- R5: Any change of output enable while the column strobe is high turns the outputs off. They stay off, even after output enable returns low, until the next column strobe fall.
- R6: A falling edge of write enable while the column strobe is high turns the outputs off.
- R7: Let E0 be the first sampling edge at which both strobes are high. With output enable held low, `dq_oe` stays 1 after edges E0 to E0+TOFF_CYC-1 and is 0 after edge E0+TOFF_CYC.
- R8: If write enable is low when the column strobe falls, the access is an early write. `wr_commit` pulses for one cycle after that edge, `din` is stored at the addressed word, and `dq_oe` stays 0 whatever output enable does.
- R9: A write enable fall while the column strobe is already low and output enable is high is a late write. `wr_commit` pulses once, `din` from that sample is stored at the column latched at the strobe fall, and the outputs are off.
- R10: A late write enable fall while output enable is low commits nothing (`wr_commit` stays 0, memory unchanged). The outputs keep driving the read word.
- R11: The row is taken from `addr` at the row strobe fall. The column is taken from `addr` at the column strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DATA_W | Write data |
| dq_oe | output | 1 | Data pins driven when 1 |
| dq_out | output | DATA_W | Word presented on the data pins |
| wr_commit | output | 1 | One-cycle pulse when a write is stored |

## Verification
Every result of this block is registered once: a strobe level change sampled at edge N shows on `dq_oe`, `dq_out` and `wr_commit` right after edge N. The bench therefore changes inputs just after an edge and checks one time unit after the next edge. The only result due later is the turn-off in R7. For that case the bench counts edges from the first sample with both strobes high and checks every edge up to and including E0+TOFF_CYC.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
  } strobe_t;

  typedef struct packed {
    logic ras_fall;
    logic cas_fall;
    logic we_fall;
    logic oe_chg;
    logic idle_now;
    logic idle_prev;
  } edges_t;

endpackage

// File: rtl/edo_strobe_sampler.sv
module edo_strobe_sampler
  import edo_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t now_s,
  output edges_t  edg
);

  strobe_t prev_q;
  strobe_t prev_d;

  always_comb begin
    prev_d = now_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
    end else begin
      prev_q <= prev_d;
    end
  end

  always_comb begin
    edg.ras_fall  = prev_q.ras_n & ~now_s.ras_n;
    edg.cas_fall  = prev_q.cas_n & ~now_s.cas_n;
    edg.we_fall   = prev_q.we_n  & ~now_s.we_n;
    edg.oe_chg    = prev_q.oe_n  ^  now_s.oe_n;
    edg.idle_now  = now_s.ras_n  &  now_s.cas_n;
    edg.idle_prev = prev_q.ras_n &  prev_q.cas_n;
  end

endmodule

// File: rtl/edo_off_timer.sv
module edo_off_timer #(
  parameter int TOFF_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_now,
  input  logic idle_prev,
  output logic expire
);

  localparam int CW = (TOFF_CYC < 1) ? 1 : $clog2(TOFF_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TOFF_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = '0;
    if (idle_now && idle_prev) begin
      cnt_d = (cnt_q == LIMIT) ? LIMIT : cnt_q + 1'b1;
    end
    expire = idle_now && (cnt_d == LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/edo_test_mem.sv
module edo_test_mem #(
  parameter int DATA_W = 8,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata = mem_q[raddr];
  end

endmodule

// File: rtl/edo_dq_ctrl.sv
module edo_dq_ctrl
  import edo_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ROW_W    = 2,
  parameter int COL_W    = 2,
  parameter int TOFF_CYC = 3,
  localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int MEM_AW  = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out,
  output logic              wr_commit
);

  strobe_t now_s;
  edges_t  edg;
  logic    expire;

  always_comb begin
    now_s.ras_n = ras_n;
    now_s.cas_n = cas_n;
    now_s.we_n  = we_n;
    now_s.oe_n  = oe_n;
  end

  edo_strobe_sampler u_samp (
    .clk   (clk),
    .rst_n (rst_n),
    .now_s (now_s),
    .edg   (edg)
  );

  edo_off_timer #(.TOFF_CYC(TOFF_CYC)) u_toff (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_now  (edg.idle_now),
    .idle_prev (edg.idle_prev),
    .expire    (expire)
  );

  logic [ROW_W-1:0]  row_q, row_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic              open_q, open_d;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              oe_q, oe_d;
  logic              commit_q, commit_d;

  logic              access, early, rd_hit, late, late_commit;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_rdata;

  always_comb begin
    access      = edg.cas_fall & ~ras_n;
    early       = access & ~we_n;
    rd_hit      = access & we_n;
    late        = open_q & ~cas_n & edg.we_fall;
    late_commit = late & oe_n;
    mem_we      = early | late_commit;
    mem_raddr   = {row_q, addr[COL_W-1:0]};
    mem_waddr   = early ? {row_q, addr[COL_W-1:0]} : {row_q, col_q};
  end

  edo_test_mem #(.DATA_W(DATA_W), .AW(MEM_AW)) u_mem (
    .clk   (clk),
    .wr_en (mem_we),
    .waddr (mem_waddr),
    .wdata (din),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  // next-state decisions
  always_comb begin
    row_d    = edg.ras_fall ? addr[ROW_W-1:0] : row_q;
    col_d    = access ? addr[COL_W-1:0] : col_q;
    open_d   = access ? 1'b1 : (cas_n ? 1'b0 : open_q);
    data_d   = rd_hit ? mem_rdata : data_q;
    commit_d = mem_we;

    valid_d = valid_q;
    if (access) begin
      valid_d = we_n;
    end else begin
      if (late_commit) begin
        valid_d = 1'b0;
      end
      if (cas_n && (edg.oe_chg || edg.we_fall)) begin
        valid_d = 1'b0;
      end
      if (expire) begin
        valid_d = 1'b0;
      end
    end
    oe_d = valid_d & ~oe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q    <= '0;
      col_q    <= '0;
      open_q   <= 1'b0;
      valid_q  <= 1'b0;
      data_q   <= '0;
      oe_q     <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      row_q    <= row_d;
      col_q    <= col_d;
      open_q   <= open_d;
      valid_q  <= valid_d;
      oe_q     <= oe_d;
      commit_q <= commit_d;
      if (rd_hit) begin
        data_q <= data_d;
      end
    end
  end

  assign dq_oe     = oe_q;
  assign dq_out    = data_q;
  assign wr_commit = commit_q;

endmodule

// File: rtl/edo_dq_ctrl_chk.sv
module edo_dq_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out,
  input logic              wr_commit
);

  // R4: pins only drive if output enable was asserted at the edge that set them
  a_r4_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!oe_n));

  // R8: early write keeps outputs off and commits
  a_r8_early_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !cas_n && $past(cas_n) && !we_n) |=> (!dq_oe && wr_commit));

  // R10: late write enable fall with output enable low commits nothing
  a_r10_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n) && !we_n && $past(we_n) && !oe_n) |=> !wr_commit);

  // R6: write enable fall with column strobe high forces high impedance
  a_r6_we_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n && $past(cas_n) && !we_n && $past(we_n)) |=> !dq_oe);

  // R5: output enable change with column strobe high forces high impedance
  a_r5_oe_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n && $past(cas_n) && (oe_n != $past(oe_n))) |=> !dq_oe);

  // R9: a commit is a single-cycle pulse
  a_r9_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

endmodule

bind edo_dq_ctrl edo_dq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/edo_dq_ctrl_bench.sv
module edo_dq_ctrl_bench;

  localparam int DW   = 8;
  localparam int RW   = 2;
  localparam int CWD  = 2;
  localparam int TOFF = 3;
  localparam int AWB  = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ras_n, cas_n, we_n, oe_n;
  logic [AWB-1:0] addr;
  logic [DW-1:0] din;
  logic          dq_oe;
  logic [DW-1:0] dq_out;
  logic          wr_commit;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [DW-1:0] shadow [16];

  always #2 clk = ~clk;

  edo_dq_ctrl #(.DATA_W(DW), .ROW_W(RW), .COL_W(CWD), .TOFF_CYC(TOFF)) u_edo_dq_ctrl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dq_oe(dq_oe), .dq_out(dq_out),
    .wr_commit(wr_commit)
  );

  function automatic logic [DW-1:0] exp_word(input int r, input int c);
    return shadow[r*4 + c];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic c, input logic w, input logic o,
                       input int a, input logic [DW-1:0] d);
    ras_n = r; cas_n = c; we_n = w; oe_n = o;
    addr = AWB'(a); din = d;
    @(posedge clk); #1;
  endtask

  task automatic close_row();
    for (int k = 0; k <= TOFF; k++) drive(1, 1, 1, 0, 0, 0);
    chk("R7 idle off", dq_oe, 0);
  endtask

  task automatic do_read(input int r, input int c, input int variant, input bit ras_first);
    drive(0, 1, 1, 0, r, 0);
    drive(0, 0, 1, 0, c, 0);
    chk("R2 oe", dq_oe, 1);
    chk("R2 R11 data", dq_out, exp_word(r, c));
    case (variant)
      0: begin
        if (ras_first) begin
          drive(1, 0, 1, 0, c, 0);
          chk("R3 hold", dq_oe, 1);
        end else begin
          drive(0, 1, 1, 0, c, 0);
          chk("R3 hold", dq_oe, 1);
          chk("R3 data", dq_out, exp_word(r, c));
        end
        drive(1, 1, 1, 0, 0, 0);
        chk("R7 E0", dq_oe, 1);
        for (int k = 1; k < TOFF; k++) begin
          drive(1, 1, 1, 0, 0, 0);
          chk("R7 window", dq_oe, 1);
        end
        drive(1, 1, 1, 0, 0, 0);
        chk("R7 off", dq_oe, 0);
      end
      1: begin
        drive(0, 0, 1, 1, c, 0);
        chk("R4 off", dq_oe, 0);
        drive(0, 0, 1, 0, c, 0);
        chk("R4 back", dq_oe, 1);
        chk("R4 same", dq_out, exp_word(r, c));
        drive(0, 1, 1, 0, c, 0);
      end
      2: begin
        drive(0, 1, 1, 0, c, 0);
        chk("R3 hold", dq_oe, 1);
        drive(0, 1, 1, 1, c, 0);
        chk("R5 off", dq_oe, 0);
        drive(0, 1, 1, 0, c, 0);
        chk("R5 stays", dq_oe, 0);
      end
      default: begin
        drive(0, 1, 1, 0, c, 0);
        drive(0, 1, 0, 0, c, 0);
        chk("R6 off", dq_oe, 0);
        drive(0, 1, 1, 0, c, 0);
        chk("R6 stays", dq_oe, 0);
      end
    endcase
    close_row();
  endtask

  task automatic do_early(input int r, input int c, input logic [DW-1:0] d);
    drive(0, 1, 1, 0, r, 0);
    drive(0, 1, 0, 0, c, 0);
    drive(0, 0, 0, 0, c, d);
    chk("R8 commit", wr_commit, 1);
    chk("R8 hiz", dq_oe, 0);
    drive(0, 0, 0, 0, c, d);
    chk("R8 pulse", wr_commit, 0);
    chk("R8 hiz", dq_oe, 0);
    shadow[r*4 + c] = d;
    drive(0, 1, 1, 0, c, 0);
    close_row();
  endtask

  task automatic do_late(input int r, input int c, input logic [DW-1:0] d, input bit oe_high);
    drive(0, 1, 1, 0, r, 0);
    drive(0, 0, 1, 0, c, 0);
    chk("R2 data", dq_out, exp_word(r, c));
    if (oe_high) begin
      drive(0, 0, 1, 1, c, 0);
      chk("R4 off", dq_oe, 0);
      drive(0, 0, 0, 1, (c + 1) % 4, d);
      chk("R9 commit", wr_commit, 1);
      drive(0, 0, 0, 1, c, d);
      chk("R9 pulse", wr_commit, 0);
      chk("R9 hiz", dq_oe, 0);
      shadow[r*4 + c] = d;
      drive(0, 1, 1, 1, c, 0);
    end else begin
      drive(0, 0, 0, 0, c, d);
      chk("R10 no commit", wr_commit, 0);
      chk("R10 drives", dq_oe, 1);
      chk("R10 data", dq_out, exp_word(r, c));
      drive(0, 1, 1, 0, c, 0);
    end
    close_row();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    rst_n = 0; ras_n = 1; cas_n = 1; we_n = 1; oe_n = 0; addr = 0; din = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 oe", dq_oe, 0);
    chk("R1 commit", wr_commit, 0);
    rst_n = 1;
    drive(1, 1, 1, 0, 0, 0);
    chk("R1 oe", dq_oe, 0);
    chk("R1 commit", wr_commit, 0);
    for (int i = 0; i < 16; i++) do_early(i / 4, i % 4, DW'(8'h11 * i + 8'h05));
    for (int i = 0; i < 16; i++) do_read(i / 4, i % 4, i % 4, i[4]);
    for (int i = 0; i < 16; i++) do_read(i / 4, i % 4, 0, 1'b1);
    for (int n = 0; n < 200; n++) begin
      int op = $urandom_range(0, 5);
      int r  = $urandom_range(0, 3);
      int c  = $urandom_range(0, 3);
      logic [DW-1:0] d = DW'($urandom);
      case (op)
        0: do_early(r, c, d);
        1: do_late(r, c, d, 1'b1);
        2: do_late(r, c, d, 1'b0);
        default: do_read(r, c, $urandom_range(0, 3), 1'($urandom_range(0, 1)));
      endcase
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule